// File: doc/BRIEF.md
# Oscillator Entropy Word Collector

This block turns a bank of free-running oscillator outputs into 32-bit random words for a processor. The oscillator lines are not related to the block clock, so they first pass through a two-stage synchronizer. A fixed-period counter then takes a snapshot of the synchronized bank and reduces it to a single parity bit. The block takes two snapshots, one interval apart, and XORs them to form one entropy bit. It shifts that bit into a word register.

Collection never stops. The word register always holds the most recent bits, and the oldest bit drops off the top as each new bit arrives. A ready flag tells software that the word holds a full set of bits that have not been handed out. When the register is read, the flag clears and the fresh-bit tally returns to zero. A whole new word of bits must then arrive before the flag rises again.

The control sits in two small state machines. The pair combiner has two states. PR_HOLD stores the first snapshot and moves to PR_COMBINE. PR_COMBINE XORs in the second snapshot, emits the bit and returns to PR_HOLD. The word tracker also has two states. WD_FILL moves to WD_FULL when the last bit of a fresh word arrives with no read in the same cycle. WD_FULL returns to WD_FILL on any read.

Top module: `entc_top`

## Requirements
- R1: In the cycle after reset, `data_ready_o` is 0 and `entropy_o` is all zeros.
- R2: The block takes a snapshot once every `SAMPLE_INTERVAL` clock edges after reset release, first at edge `SAMPLE_INTERVAL`. The snapshot is the XOR of all `NUM_OSC` oscillator lines, using the value those lines held two edges earlier (two-flop synchronizer).
- R3: Snapshots are grouped in non-overlapping pairs (1st with 2nd, 3rd with 4th, and so on). Each entropy bit is the XOR of the two snapshots in its pair. The bit lands in `entropy_o` two edges after the second snapshot of the pair.
- R4: Each new entropy bit enters at bit 0 of `entropy_o`. Earlier bits move one place toward bit `WORD_W-1`, and the bit at the top is discarded. Bit `WORD_W-1` therefore holds the oldest of the last `WORD_W` bits.
- R5: `data_ready_o` rises in the same cycle as the `WORD_W`-th fresh bit lands. Fresh bits are those counted since reset or since the last read.
- R6: A read is `rd_i` high at a clock edge. It clears `data_ready_o` from the next cycle and sets the fresh-bit tally to zero. A bit that lands on the same edge as the read is not counted.
- R7: While no read occurs, `data_ready_o` stays high once set, even as further bits shift into the word.
- R8: The pair combiner alternates PR_HOLD and PR_COMBINE on each snapshot. It emits a bit only when leaving PR_COMBINE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| osc_i | input | NUM_OSC | Raw oscillator lines, asynchronous to clk_i |
| rd_i | input | 1 | Read strobe for the entropy word |
| data_ready_o | output | 1 | A full fresh word is available |
| entropy_o | output | WORD_W | Current entropy word |

## Verification
The bench builds the block with `NUM_OSC` = 12, `SAMPLE_INTERVAL` = 8 and `WORD_W` = 32. At these values a bit lands every 16 cycles, so several complete words fit in a few thousand cycles. That makes it practical to check exact ready-rise cycles, word contents built from chosen snapshot parities, and the discard of old bits. The bench changes the oscillator pattern midway between snapshots, which makes the expected parity of each snapshot unambiguous despite the synchronizer. It also places a read on the very edge where a bit lands, to exercise the rule that such a bit is not counted.

// File: rtl/entc_pkg.sv
package entc_pkg;

    typedef enum logic {
        PR_HOLD    = 1'b0,
        PR_COMBINE = 1'b1
    } pair_state_e;

    typedef enum logic {
        WD_FILL = 1'b0,
        WD_FULL = 1'b1
    } word_state_e;

endpackage

// File: rtl/entc_sync.sv
module entc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[g] <= '0;
                    else       stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[g] <= '0;
                    else       stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/entc_sampler.sv
module entc_sampler #(
    parameter int NUM_OSC         = 32,
    parameter int SAMPLE_INTERVAL = 4096
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_OSC-1:0] osc_sync_i,
    output logic               samp_vld_o,
    output logic               samp_bit_o
);

    localparam int CNT_W = (SAMPLE_INTERVAL > 1) ? $clog2(SAMPLE_INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q      <= '0;
            samp_vld_o <= 1'b0;
            samp_bit_o <= 1'b0;
        end else begin
            cnt_q      <= wrap ? '0 : cnt_q + 1'b1;
            samp_vld_o <= wrap;
            if (wrap) samp_bit_o <= ^osc_sync_i;
        end
    end

    // R2: a snapshot follows a counter wrap, so the counter restarts at zero
    a_r2_snap_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        samp_vld_o |-> (cnt_q == '0));

    // R2: snapshots are never back to back when the interval exceeds one
    a_r2_snap_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        (samp_vld_o && (SAMPLE_INTERVAL > 1)) |=> !samp_vld_o);

endmodule

// File: rtl/entc_pair.sv
module entc_pair
    import entc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic samp_vld_i,
    input  logic samp_bit_i,
    output logic bit_vld_o,
    output logic bit_o
);

    pair_state_e st_q, st_d;
    logic        held_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PR_HOLD:    if (samp_vld_i) st_d = PR_COMBINE;
            PR_COMBINE: if (samp_vld_i) st_d = PR_HOLD;
            default:    st_d = PR_HOLD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= PR_HOLD;
        else       st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            held_q    <= 1'b0;
            bit_vld_o <= 1'b0;
            bit_o     <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            unique case (st_q)
                PR_HOLD: if (samp_vld_i) held_q <= samp_bit_i;
                PR_COMBINE: if (samp_vld_i) begin
                    bit_vld_o <= 1'b1;
                    bit_o     <= held_q ^ samp_bit_i;
                end
                default: ;
            endcase
        end
    end

    // R8: a snapshot in PR_HOLD moves to PR_COMBINE without emitting
    a_r8_hold_to_combine: assert property (@(posedge clk_i) disable iff (rst_i)
        (samp_vld_i && st_q == PR_HOLD) |=> (st_q == PR_COMBINE && !bit_vld_o));

    // R3: an emitted bit always leaves the combiner back in PR_HOLD
    a_r3_emit_returns_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_o |-> (st_q == PR_HOLD));

endmodule

// File: rtl/entc_top.sv
module entc_top
    import entc_pkg::*;
#(
    parameter int NUM_OSC         = 32,
    parameter int SAMPLE_INTERVAL = 4096,
    parameter int WORD_W          = 32,
    parameter int SYNC_STAGES     = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic               rd_i,
    output logic               data_ready_o,
    output logic [WORD_W-1:0]  entropy_o
);

    localparam int FRESH_W = $clog2(WORD_W + 1);
    localparam logic [FRESH_W-1:0] LAST_FRESH = FRESH_W'(WORD_W - 1);

    logic [NUM_OSC-1:0] osc_sync;
    logic               samp_vld, samp_bit;
    logic               bit_vld, ebit;
    logic [FRESH_W-1:0] fresh_q;
    word_state_e        st_q, st_d;

    entc_sync #(.WIDTH(NUM_OSC), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (osc_i),
        .q_o   (osc_sync)
    );

    entc_sampler #(.NUM_OSC(NUM_OSC), .SAMPLE_INTERVAL(SAMPLE_INTERVAL)) samp_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .osc_sync_i (osc_sync),
        .samp_vld_o (samp_vld),
        .samp_bit_o (samp_bit)
    );

    entc_pair pair_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .samp_vld_i (samp_vld),
        .samp_bit_i (samp_bit),
        .bit_vld_o  (bit_vld),
        .bit_o      (ebit)
    );

    // word tracker next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_FILL: if (bit_vld && !rd_i && fresh_q == LAST_FRESH) st_d = WD_FULL;
            WD_FULL: if (rd_i) st_d = WD_FILL;
            default: st_d = WD_FILL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= WD_FILL;
        else       st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            entropy_o <= '0;
            fresh_q   <= '0;
        end else begin
            if (bit_vld) entropy_o <= {entropy_o[WORD_W-2:0], ebit};
            if (rd_i)
                fresh_q <= '0;
            else if (bit_vld && st_q == WD_FILL)
                fresh_q <= fresh_q + 1'b1;
        end
    end

    assign data_ready_o = (st_q == WD_FULL);

    // R6: a read drops the ready flag on the following cycle
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> !data_ready_o);

    // R7: without a read the ready flag holds
    a_r7_ready_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (data_ready_o && !rd_i) |=> data_ready_o);

    // R4: a landing bit moves the older bits one place up
    a_r4_shift_up: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld |=> (entropy_o[WORD_W-1:1] == $past(entropy_o[WORD_W-2:0])));

    // R5: ready only rises once a full word of fresh bits is tallied
    a_r5_rise_full: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(data_ready_o) |-> (fresh_q == FRESH_W'(WORD_W)));

    // R4: without a landing bit the word holds still
    a_r4_word_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_vld |=> $stable(entropy_o));

endmodule

// File: tb/entc_top_tb.sv
module entc_top_tb_top;

    localparam int  NOSC     = 12;
    localparam int  IVL      = 8;
    localparam int  WW       = 32;
    localparam time CLK_PER  = 10ns;
    localparam int  BIT_CYC  = 2 * IVL;
    localparam int  WORD_CYC = BIT_CYC * WW;
    localparam int  WDOG     = 8000;

    // stimulus/expected table: each word is both the target stream and the expected read value
    localparam logic [31:0] VEC_TAB [4] = '{
        32'hA5A5_0F0F, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NOSC-1:0] osc = '0;
    logic            rd  = 1'b0;
    logic            rdy;
    logic [WW-1:0]   word;
    int              cyc = 0;
    int              n_chk = 0;
    int              n_bad = 0;
    bit              done = 1'b0;

    entc_top #(.NUM_OSC(NOSC), .SAMPLE_INTERVAL(IVL), .WORD_W(WW)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .osc_i        (osc),
        .rd_i         (rd),
        .data_ready_o (rdy),
        .entropy_o    (word)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    function automatic logic sbit(int j);
        if (j < 4 * WW) return VEC_TAB[j / WW][WW - 1 - (j % WW)];
        return 1'(j ^ (j >> 1) ^ (j >> 3));
    endfunction

    function automatic logic [NOSC-1:0] osc_for(int s);
        int              j = s / 2;
        logic            tgt;
        logic [31:0]     h = 32'(s) * 32'h9E37_79B1;
        logic [NOSC-1:0] v = NOSC'(h >> 7);
        tgt = 1'((j >> 2) & 1);
        if (s % 2 == 1) tgt = tgt ^ sbit(j);
        if ((^v) != tgt) v[0] = ~v[0];
        return v;
    endfunction

    function automatic logic [WW-1:0] exp_word(int last);
        logic [WW-1:0] w;
        for (int i = 0; i < WW; i++) w[i] = sbit(last - i);
        return w;
    endfunction

    // change the bank midway between snapshots so the synchronizer delay is irrelevant
    always @(negedge clk) if (!rst && (cyc % IVL) == IVL / 2) osc <= osc_for(cyc / IVL);

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_ready(int exp_cyc, string tag);
        while (!rdy && cyc < WDOG) @(negedge clk);
        chk(cyc == exp_cyc, tag, 64'(cyc), 64'(exp_cyc));
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rdy == 1'b0, "R1 ready after reset", 64'(rdy), 64'd0);
        chk(word == '0, "R1 word after reset", 64'(word), 64'd0);

        // table walk: R2/R3/R4 contents, R5 rise cycle, R6 clear on read
        for (int k = 0; k < 4; k++) begin
            wait_ready(WORD_CYC * (k + 1) + 2, "R5 ready rise cycle");
            chk(word == VEC_TAB[k], "R3/R4 table word", 64'(word), 64'(VEC_TAB[k]));
            do_read();
            chk(rdy == 1'b0, "R6 ready after read", 64'(rdy), 64'd0);
        end

        // R7: no read, ready holds while old bits drop off the top
        wait_ready(WORD_CYC * 5 + 2, "R5 fifth word rise");
        while (cyc < 16 * 165 + 8) @(negedge clk);
        chk(rdy == 1'b1, "R7 ready held", 64'(rdy), 64'd1);
        chk(word == exp_word(164), "R4 discard oldest", 64'(word), 64'(exp_word(164)));

        // R6: read on the edge where bit 165 lands; that bit is not counted
        while (cyc < 16 * 166 + 1) @(negedge clk);
        do_read();
        chk(rdy == 1'b0, "R6 coincident read clears", 64'(rdy), 64'd0);
        wait_ready(16 * 166 + 2 + WORD_CYC, "R6 coincident bit not counted");
        chk(word == exp_word(197), "R3 word after coincident read", 64'(word),
            64'(exp_word(197)));

        // R8: word before ready rise must not have partial pairing drift (checked via content)
        chk(word[0] == sbit(197), "R8 latest bit pairing", 64'(word[0]), 64'(sbit(197)));

        done = 1'b1;
        finish_run();
    end

    initial begin
        while (cyc < WDOG) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            finish_run();
        end
    end

endmodule